// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Fabric

This block joins N interrupt sources that share a single request line to one processor. Each source owns a slice. A one-cycle raise strobe marks the slice as pending, and every pending flag feeds a common OR-ed request toward the processor. When the processor answers with an acknowledge pulse, the pulse enters slice 0 and moves along the chain in index order. Each slice makes its decision on the rising edge of its own acknowledge input. A slice with a pending request keeps the pulse and does not forward it. Every other slice forwards the pulse to the next one.

The slice that keeps the pulse drops its pending flag. For as long as the acknowledge stays high, it places its index on the shared vector bus, and the processor uses that index to select a handler. Priority comes only from position in the chain, so the scheme is simple but gives no fairness. If no slice keeps the pulse, the vector bus reads all ones, a spurious flag is raised, and the pulse leaves the far end of the chain.

Top module: `irq_daisy_chain`

## Requirements
- R1: `irq_o` is the OR of all pending flags, registered once. It rises on the clock edge after a pending flag is set and falls on the clock edge after the last pending flag clears.
- R2: A high bit in `dev_raise_i` at a clock edge sets that slice's pending flag. The flag stays set until that slice takes an acknowledge.
- R3: At an acknowledge rising edge, the pending slice with the lowest index takes the acknowledge. Index 0 has the highest priority.
- R4: A slice that takes the acknowledge does not forward it. `chain_ack_o` (the acknowledge leaving slice N-1) is high only while an acknowledge is high that no slice took.
- R5: While `cpu_ack_i` is high and a slice has taken it, `vec_o` equals that slice's index as an unsigned binary number. The value stays constant for the whole pulse, whatever its length.
- R6: `vec_o` is all ones when no slice holds the acknowledge, which includes the time when `cpu_ack_i` is low. `spurious_o` updates on the clock edge that follows each acknowledge rising edge: it goes to 1 if no slice took that pulse and to 0 otherwise, and it holds its value until the next rising edge.
- R7: The taking slice clears its pending flag at the acknowledge rising edge. If no other flag is pending, `irq_o` falls one clock later.
- R8: A raise that arrives in the same cycle as a slice's acknowledge rising edge, or later in the same pulse, does not take that pulse. It is served by a later pulse.
- R9: No fairness is provided. A lower-index slice that raises again before every acknowledge wins every time, and a pending higher-index slice waits until the lower-index slice stops raising.
- R10: After reset, all pending flags are clear, `irq_o` is 0, `spurious_o` is 0, `chain_ack_o` is 0 and `vec_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_raise_i | input | N | Per-slice raise strobe, one bit per source |
| cpu_ack_i | input | 1 | Acknowledge pulse from the processor, one or more cycles long |
| irq_o | output | 1 | Registered combined request |
| vec_o | output | W = clog2(N+1) | Index of the taking slice, or all ones |
| spurious_o | output | 1 | The last acknowledge found no taker |
| chain_ack_o | output | 1 | Acknowledge leaving the last slice |

## Verification
The hardest case to reach from the ports is a raise that lands inside a pulse that has already passed its slice. To reach it, the bench raises one slice in the same cycle as the acknowledge rising edge and raises another in the middle of a held pulse, then checks that the vector bus keeps its value and that the late request only wins on the following pulse. Starvation is produced by re-raising slice 0 before every pulse in a loop while slice 3 stays pending, and then confirming that slice 3 is served once the re-raising stops.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    // Register state of one chain slice
    typedef struct packed {
        logic pend;      // request not yet served
        logic ack_prev;  // acknowledge input of the previous cycle
        logic take;      // this slice kept the current pulse
    } slice_state_t;

    // Register state of the top level
    typedef struct packed {
        logic irq;
        logic ack_prev;
        logic spur;
    } top_state_t;

endpackage

// File: rtl/irq_slice.sv
module irq_slice
    import irq_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise_i,
    input  logic ack_i,
    output logic ack_o,
    output logic grant_o,
    output logic pend_o
);

    slice_state_t st_d, st_q;
    logic         rise;
    logic         keep;

    always_comb begin
        st_d  = st_q;
        rise  = ack_i & ~st_q.ack_prev;
        // The decision is made at the rising edge and then latched for the rest of the pulse
        keep  = rise ? st_q.pend : st_q.take;
        grant_o = ack_i & keep;
        ack_o   = ack_i & ~keep;

        st_d.ack_prev = ack_i;
        st_d.take     = ack_i & keep;
        if (rise && st_q.pend)
            st_d.pend = 1'b0;
        if (raise_i)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R4: a slice never forwards an acknowledge it has taken
    p_no_pass_when_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> !ack_o);

    // R4: nothing leaves a slice that did not enter it
    p_no_ack_from_nowhere_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ack_i);

    // R7: the taker withdraws its request at the rising edge
    p_withdraw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !st_q.ack_prev && st_q.pend && !raise_i) |=> !pend_o);

    // R8: once a pulse has been passed on, it stays passed on
    p_late_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && st_q.ack_prev && !st_q.take) |-> ack_o);

endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc #(
    parameter int N = 4,
    parameter int W = $clog2(N + 1)
) (
    input  logic [N-1:0] grant_i,
    output logic [W-1:0] vec_o,
    output logic         any_o
);

    always_comb begin
        vec_o = '1;
        any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (grant_i[i]) begin
                vec_o = W'(i);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
    import irq_chain_pkg::*;
#(
    parameter int N = 4,
    localparam int W = $clog2(N + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] dev_raise_i,
    input  logic         cpu_ack_i,
    output logic         irq_o,
    output logic [W-1:0] vec_o,
    output logic         spurious_o,
    output logic         chain_ack_o
);

    logic [N:0]   ack_chain;
    logic [N-1:0] grant;
    logic [N-1:0] pend;
    logic         any_grant;
    top_state_t   st_d, st_q;

    assign ack_chain[0] = cpu_ack_i;

    for (genvar g = 0; g < N; g++) begin : g_slice
        irq_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .raise_i (dev_raise_i[g]),
            .ack_i   (ack_chain[g]),
            .ack_o   (ack_chain[g+1]),
            .grant_o (grant[g]),
            .pend_o  (pend[g])
        );
    end

    irq_vec_enc #(.N(N), .W(W)) u_enc (
        .grant_i (grant),
        .vec_o   (vec_o),
        .any_o   (any_grant)
    );

    always_comb begin
        st_d          = st_q;
        st_d.irq      = |pend;
        st_d.ack_prev = cpu_ack_i;
        if (cpu_ack_i && !st_q.ack_prev)
            st_d.spur = ~any_grant;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign irq_o       = st_q.irq;
    assign spurious_o  = st_q.spur;
    assign chain_ack_o = ack_chain[N];

    // R3: at most one slice holds the acknowledge
    p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R1: a pending request is visible on the request line one cycle later
    p_irq_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |=> irq_o);

    // R5: the vector holds steady through a held acknowledge
    p_vec_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack_i && $past(cpu_ack_i) && st_q.ack_prev) |-> $stable(vec_o));

    // R6: a spurious pulse runs off the end of the chain
    p_spur_passes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack_i && st_q.ack_prev && spurious_o) |-> chain_ack_o);

    // R4: the chain tail and a valid vector exclude each other
    p_tail_vs_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chain_ack_o |-> (vec_o == '1));

endmodule

// File: tb/tb_irq_daisy_chain.sv
module tb_irq_daisy_chain;

    localparam int N = 4;
    localparam int W = 3;
    localparam logic [W-1:0] NONE = '1;
    localparam int NV = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] dev_raise_i = '0;
    logic         cpu_ack_i = 1'b0;
    logic         irq_o;
    logic [W-1:0] vec_o;
    logic         spurious_o;
    logic         chain_ack_o;

    int n_checks = 0;
    int n_fail   = 0;

    // Table: raise mask, expected irq before the pulse, expected vector during the pulse
    localparam logic [N-1:0] T_RAISE [NV] = '{4'b0100, 4'b1010, 4'b0000, 4'b0000, 4'b1111,
                                              4'b0001, 4'b0000, 4'b0000, 4'b0000};
    localparam logic         T_IRQ   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
                                              1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [W-1:0] T_VEC   [NV] = '{3'd2, 3'd1, 3'd3, 3'd7, 3'd0,
                                              3'd0, 3'd1, 3'd2, 3'd3};

    irq_daisy_chain #(.N(N)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_raise_i (dev_raise_i),
        .cpu_ack_i   (cpu_ack_i),
        .irq_o       (irq_o),
        .vec_o       (vec_o),
        .spurious_o  (spurious_o),
        .chain_ack_o (chain_ack_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic raise(input logic [N-1:0] m);
        @(negedge clk) dev_raise_i = m;
        @(negedge clk) dev_raise_i = '0;
    endtask

    // Two-cycle acknowledge pulse; checks vector, tail and spurious flag
    task automatic ack_pulse(input logic [W-1:0] exp_vec, input string tag);
        @(negedge clk) cpu_ack_i = 1'b1;
        #2;
        check({tag, " R3 R5 vector at rise"}, vec_o, exp_vec);
        check({tag, " R4 chain tail"}, chain_ack_o, exp_vec == NONE);
        @(negedge clk) #2;
        check({tag, " R5 vector held"}, vec_o, exp_vec);
        check({tag, " R6 spurious flag"}, spurious_o, exp_vec == NONE);
        @(negedge clk) cpu_ack_i = 1'b0;
        #2;
        check({tag, " R6 idle vector"}, vec_o, NONE);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check("R10 irq in reset", irq_o, 0);
        check("R10 vector in reset", vec_o, NONE);
        rst_n = 1'b1;
        @(negedge clk) #2;
        check("R10 irq after reset", irq_o, 0);
        check("R10 spurious after reset", spurious_o, 0);
        check("R10 tail after reset", chain_ack_o, 0);
        check("R10 vector after reset", vec_o, NONE);

        // Table walk (R1 R2 R3 R7)
        for (int k = 0; k < NV; k++) begin
            raise(T_RAISE[k]);
            @(negedge clk) #2;
            check("R1 R2 R7 irq before pulse", irq_o, T_IRQ[k]);
            ack_pulse(T_VEC[k], "table");
        end
        @(negedge clk) #2;
        check("R7 irq falls after last taker", irq_o, 0);

        // R8: raise coinciding with the rising edge does not win that pulse
        @(negedge clk) begin cpu_ack_i = 1'b1; dev_raise_i = 4'b0001; end
        #2;
        check("R8 same-cycle raise misses", vec_o, NONE);
        @(negedge clk) begin cpu_ack_i = 1'b0; dev_raise_i = '0; end
        ack_pulse(3'd0, "R8 served next");

        // R8: raise in the middle of a held pulse
        raise(4'b0100);
        @(negedge clk) cpu_ack_i = 1'b1;
        #2;
        check("R8 taker before late raise", vec_o, 2);
        @(negedge clk) dev_raise_i = 4'b0001;
        @(negedge clk) dev_raise_i = '0;
        #2;
        check("R8 R5 vector unchanged by late raise", vec_o, 2);
        repeat (2) @(negedge clk);
        #2;
        check("R5 long pulse still stable", vec_o, 2);
        cpu_ack_i = 1'b0;
        @(negedge clk) #2;
        check("R8 late request still pending", irq_o, 1);
        ack_pulse(3'd0, "R8 late served");

        // R9: starvation of slice 3
        raise(4'b1000);
        for (int s = 0; s < 8; s++) begin
            raise(4'b0001);
            ack_pulse(3'd0, "R9 slice 0 wins");
            @(negedge clk) #2;
            check("R9 slice 3 still waiting", irq_o, 1);
        end
        ack_pulse(3'd3, "R9 slice 3 finally");
        repeat (2) @(negedge clk);
        #2;
        check("R1 idle after drain", irq_o, 0);

        report();
    end

endmodule